// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block sits between a 32-bit processor load/store port and a word-wide main-memory port. It holds recently used lines in a parameterizable number of ways and sets. A lookup that matches a valid way is served straight from the data array in the same cycle. A lookup that matches no way allocates a line. Reads and writes both allocate. The cache picks a victim way and, if that line holds modified data, copies it back to memory. It then fetches the whole new line, one word per handshake, before the pending access completes.

Each line keeps its tag and three single bits: present, modified and recently used. Replacement uses a one-bit relative recency scheme rather than a full ordering. The default build has 4 ways, 32 sets, 64-byte lines and 32-bit addresses and words, which gives a 21-bit tag. Setting the set count to 256 gives the 18/8/6 tag/index/offset split. The tag width always follows from the address width, set count and line size.

Both sides use valid/ready handshakes. On the processor side, a request is taken in the cycle where `cpu_valid` and `cpu_ready` are both high. While `cpu_ready` is low, the requester must hold the request and all its fields unchanged. On the memory side, the cache raises `mem_valid` and holds the address, direction and write data unchanged until `mem_ready` is seen high at a clock edge. Read data on `mem_rdata` is taken at that same edge.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high with no request, and `mem_valid` is low. The first access to any address is therefore a miss.
- R2: A read that hits returns the stored word on `cpu_rdata` in the same cycle, with `cpu_ready` high. It causes no memory transfer.
- R3: A line fill reads exactly one line of words, 16 by default. It starts at the address formed from the request tag and index with all offset bits zero, and steps up by 4 bytes per handshake.
- R4: A write that hits updates only byte lanes whose `cpu_be` bit is set (bit i covers data bits 8i+7..8i). It completes with no stall and marks the line modified. Memory is not written.
- R5: A read or write miss holds `cpu_ready` low from the miss cycle until the fill ends. The access completes in the cycle after the last fill word. With a zero-wait memory, a clean miss stalls 17 cycles.
- R6: A write miss merges its masked bytes into the freshly filled line. The line is then marked modified.
- R7: The victim is the lowest-numbered invalid way in the set, if one exists.
- R8: If all ways are valid, the victim is the lowest-numbered way whose recency bit is 0. Every hit or fill sets the used way's bit. If that leaves all bits in the set at 1, the bits of all other ways are cleared.
- R9: A valid modified victim is written back first: one line of ascending words at the address built from its stored tag and the index. The fill follows directly. With a zero-wait memory, such a miss stalls 33 cycles. A filled line starts unmodified.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R11: A processor access is taken only on a cycle with `cpu_valid` and `cpu_ready` both high. A held request that was stalled completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request accepted this cycle (hit and idle) |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte-lane enables |
| cpu_rdata | output | DATA_W | Load data, valid when the request is taken |
| mem_valid | output | 1 | Memory word transfer requested |
| mem_ready | input | 1 | Memory accepts/returns the word this cycle |
| mem_we | output | 1 | 1 = write-back word, 0 = fill word |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Fill data, sampled with `mem_ready` |

## Verification
The cache is driven with a short directed conflict sequence in a single set. This sequence tells lowest-invalid victim choice apart from recency-based choice, and shows that clearing the other recency bits spares the just-used way. Masked stores to cold and warm lines tell a merged write-miss apart from a write-hit. A forced eviction of a modified line shows that write-back happens before the fill and lands at the old address. Constrained-random loads and stores follow, over a few conflicting sets and a handful of tags, with a memory that stalls at random and then with a zero-wait memory. Against a flat golden memory and a bench recency model, these runs tell correct data and hit/miss/write-back decisions apart from stale-data, lost-write and wrong-victim faults. The zero-wait run also pins down exact stall counts.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_WBACK = 2'd1,
    C_FILL  = 2'd2
  } cache_state_e;
endpackage

// File: rtl/cache_tag_match.sv
// Parallel tag compare across the ways of one set; encodes the matching way.
module cache_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_valid[w] && (set_tags[w] == req_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_victim_sel.sv
// Victim choice: lowest invalid way, else lowest way with recency bit clear.
module cache_victim_sel #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_recent,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    victim = '0;
    if (&set_valid) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!set_recent[w]) victim = WAY_W'(w);
      end
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!set_valid[w]) victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_recency.sv
// One-bit relative recency update for a set.
module cache_recency #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  cur,
  input  logic [WAY_W-1:0] way,
  output logic [WAYS-1:0]  nxt
);
  logic [WAYS-1:0] one_hot;
  logic [WAYS-1:0] marked;

  always_comb begin
    one_hot = '0;
    one_hot[way] = 1'b1;
    marked = cur | one_hot;
    nxt = (&marked) ? one_hot : marked;
  end
endmodule

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  import cache_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int BOFF_W = $clog2(BYTES);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WORDS  = LINE_BYTES / BYTES;
  localparam int WOFF_W = OFF_W - BOFF_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Storage
  logic [DATA_W-1:0] data_q  [WAYS][SETS][WORDS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-1:0]   recent_q[SETS];

  // Miss bookkeeping
  cache_state_e      state_q;
  logic [WOFF_W-1:0] cnt_q;
  logic [WAY_W-1:0]  vict_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  new_tag_q;
  logic [TAG_W-1:0]  old_tag_q;

  // Request decode
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_word;
  logic              unused_byte_off;

  assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_addr[OFF_W +: IDX_W];
  assign req_word = cpu_addr[BOFF_W +: WOFF_W];
  assign unused_byte_off = ^cpu_addr[BOFF_W-1:0];

  // Lookup
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           victim;

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_idx][w];
  end

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .set_tags (set_tags),
    .set_valid(valid_q[req_idx]),
    .req_tag  (req_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  cache_victim_sel #(.WAYS(WAYS)) u_victim (
    .set_valid (valid_q[req_idx]),
    .set_recent(recent_q[req_idx]),
    .victim    (victim)
  );

  // Control
  logic idle, acc_fire, miss_start, last_word, xfer, fill_done;

  assign idle       = (state_q == C_IDLE);
  assign cpu_ready  = idle && (!cpu_valid || hit);
  assign acc_fire   = cpu_valid && cpu_ready;
  assign miss_start = idle && cpu_valid && !hit;
  assign last_word  = (cnt_q == WOFF_W'(WORDS - 1));
  assign xfer       = mem_valid && mem_ready;
  assign fill_done  = (state_q == C_FILL) && mem_ready && last_word;

  assign cpu_rdata  = data_q[hit_way][req_idx][req_word];

  // Recency update: shared by hit completion and fill end (never together)
  logic [IDX_W-1:0] rec_idx;
  logic [WAY_W-1:0] rec_way;
  logic [WAYS-1:0]  rec_next;

  assign rec_idx = (state_q == C_FILL) ? idx_q  : req_idx;
  assign rec_way = (state_q == C_FILL) ? vict_q : hit_way;

  cache_recency #(.WAYS(WAYS)) u_recency (
    .cur(recent_q[rec_idx]),
    .way(rec_way),
    .nxt(rec_next)
  );

  // Memory port
  assign mem_valid = (state_q == C_WBACK) || (state_q == C_FILL);
  assign mem_we    = (state_q == C_WBACK);
  assign mem_addr  = (state_q == C_WBACK)
                   ? {old_tag_q, idx_q, cnt_q, {BOFF_W{1'b0}}}
                   : {new_tag_q, idx_q, cnt_q, {BOFF_W{1'b0}}};
  assign mem_wdata = data_q[vict_q][idx_q][cnt_q];

  // Miss state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= C_IDLE;
      cnt_q     <= '0;
      vict_q    <= '0;
      idx_q     <= '0;
      new_tag_q <= '0;
      old_tag_q <= '0;
    end else begin
      unique case (state_q)
        C_IDLE: begin
          if (miss_start) begin
            vict_q    <= victim;
            idx_q     <= req_idx;
            new_tag_q <= req_tag;
            old_tag_q <= tag_q[req_idx][victim];
            cnt_q     <= '0;
            state_q   <= (valid_q[req_idx][victim] && dirty_q[req_idx][victim])
                       ? C_WBACK : C_FILL;
          end
        end
        C_WBACK: begin
          if (xfer) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_word) state_q <= C_FILL;
          end
        end
        C_FILL: begin
          if (xfer) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_word) state_q <= C_IDLE;
          end
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  // Line metadata
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s]  <= '0;
        dirty_q[s]  <= '0;
        recent_q[s] <= '0;
      end
    end else if (fill_done) begin
      tag_q[idx_q][vict_q]   <= new_tag_q;
      valid_q[idx_q][vict_q] <= 1'b1;
      dirty_q[idx_q][vict_q] <= 1'b0;
      recent_q[idx_q]        <= rec_next;
    end else if (acc_fire) begin
      recent_q[req_idx] <= rec_next;
      if (cpu_we) dirty_q[req_idx][hit_way] <= 1'b1;
    end
  end

  // Data array
  always_ff @(posedge clk) begin
    if ((state_q == C_FILL) && mem_ready) begin
      data_q[vict_q][idx_q][cnt_q] <= mem_rdata;
    end else if (acc_fire && cpu_we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (cpu_be[b]) data_q[hit_way][req_idx][req_word][8*b +: 8] <= cpu_wdata[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);

  logic last_beat;
  assign last_beat = &mem_addr[OFF_W-1:BOFF_W];

  // R5
  ready_low_in_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_ready);

  // R2
  no_mem_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> !mem_valid);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

  // R3
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !last_beat) |=>
      (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8)
       && mem_we == $past(mem_we)));

  // R9
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we && last_beat) |=>
      (mem_valid && !mem_we && mem_addr[OFF_W-1:0] == '0));

  // R3
  line_aligned_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

bind wb_cache cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/wb_cache_tb.sv
module wb_cache_tb;
  localparam int SETS  = 32;
  localparam int WAYS  = 4;
  localparam int MEMW  = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wb_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [MEMW];
  logic [31:0] gold[MEMW];
  bit   fast = 1'b1;
  int   rd_cnt = 0, wr_cnt = 0, rd_seen = 0, wr_seen = 0;
  logic [31:0] exp_fill = '0, exp_wb = '0;
  bit   pend = 1'b0, pend_we = 1'b0;
  logic [31:0] pend_addr = '0;

  logic [20:0] m_tag  [SETS][WAYS];
  bit          m_val  [SETS][WAYS];
  bit          m_dirty[SETS][WAYS];
  bit          m_rec  [SETS][WAYS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Memory model: decides and performs the transfer in the low phase.
  always @(negedge clk) begin
    if (pend && mem_valid)
      check(mem_addr == pend_addr && mem_we == pend_we, "R10", "held memory request",
            mem_addr, pend_addr);
    mem_ready = mem_valid && (fast || ($urandom % 3 != 0));
    pend      = mem_valid && !mem_ready;
    pend_addr = mem_addr;
    pend_we   = mem_we;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        check(mem_addr == exp_wb + 32'(4 * wr_seen), "R9", "write-back address",
              mem_addr, exp_wb + 32'(4 * wr_seen));
        mem[mem_addr[13:2]] = mem_wdata;
        wr_seen++; wr_cnt++;
      end else begin
        check(mem_addr == exp_fill + 32'(4 * rd_seen), "R3", "fill address",
              mem_addr, exp_fill + 32'(4 * rd_seen));
        mem_rdata = mem[mem_addr[13:2]];
        rd_seen++; rd_cnt++;
      end
    end
  end

  task automatic touch(input int s, input int w);
    bit all;
    m_rec[s][w] = 1'b1;
    all = 1'b1;
    for (int i = 0; i < WAYS; i++) if (!m_rec[s][i]) all = 1'b0;
    if (all) for (int i = 0; i < WAYS; i++) m_rec[s][i] = (i == w);
  endtask

  task automatic predict(input logic [31:0] a, input bit we, output bit hit, output bit wb);
    int s, w;
    s = int'(a[10:6]);
    w = -1;
    wb = 1'b0;
    for (int i = 0; i < WAYS; i++) if (m_val[s][i] && m_tag[s][i] == a[31:11]) w = i;
    hit = (w >= 0);
    if (!hit) begin
      for (int i = WAYS - 1; i >= 0; i--) if (!m_rec[s][i]) w = i;
      for (int i = WAYS - 1; i >= 0; i--) if (!m_val[s][i]) w = i;
      if (w < 0) w = 0;
      wb = m_val[s][w] && m_dirty[s][w];
      exp_wb   = {m_tag[s][w], a[10:6], 6'b0};
      exp_fill = {a[31:6], 6'b0};
      m_tag[s][w] = a[31:11];
      m_val[s][w] = 1'b1;
      m_dirty[s][w] = 1'b0;
      touch(s, w);
    end
    touch(s, w);
    if (we) m_dirty[s][w] = 1'b1;
  endtask

  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd,
                        input logic [3:0] be, output int fills);
    bit hit, wb;
    int rd0, wr0, stalls;
    logic [31:0] got, exp;
    predict(a, we, hit, wb);
    @(negedge clk);
    rd_seen = 0; wr_seen = 0; rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    stalls = 0;
    forever begin
      #1;
      if (cpu_ready === 1'b1) break;
      stalls++;
      if (stalls > 3000) begin
        check(1'b0, "R11", "request never taken", 32'(stalls), 0);
        break;
      end
      @(negedge clk);
    end
    got = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_valid = 1'b0;
    fills = rd_cnt - rd0;
    exp = gold[a[13:2]];
    if (!we) check(got == exp, hit ? "R2" : "R5", "read data", got, exp);
    else for (int b = 0; b < 4; b++) if (be[b]) gold[a[13:2]][8*b +: 8] = wd[8*b +: 8];
    check(fills == (hit ? 0 : 16), hit ? "R2" : "R5", "fill words",
          32'(fills), hit ? 32'd0 : 32'd16);
    check(wr_cnt - wr0 == (wb ? 16 : 0), wb ? "R9" : "R4", "write-back words",
          32'(wr_cnt - wr0), wb ? 32'd16 : 32'd0);
    if (hit) check(stalls == 0, "R11", "hit stall cycles", 32'(stalls), 0);
    else if (fast) check(stalls == (wb ? 33 : 17), wb ? "R9" : "R5", "miss stall cycles",
                         32'(stalls), wb ? 32'd33 : 32'd17);
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx, input int word);
    return 32'((tag << 11) | (idx << 6) | (word << 2));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int f;
    void'($urandom(32'd5150));
    for (int i = 0; i < MEMW; i++) begin
      mem[i]  = 32'h1000_0000 + 32'(i) * 32'h0001_0003;
      gold[i] = mem[i];
    end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 0; m_dirty[s][w] = 0; m_rec[s][w] = 0; m_tag[s][w] = '0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1'b1, "R1", "ready with no request", 32'(cpu_ready), 1);
    check(mem_valid == 1'b0, "R1", "memory idle after reset", 32'(mem_valid), 0);

    // R7 / R8: conflict sequence in set 5, zero-wait memory
    access(mk(1, 5, 3), 0, 0, 0, f); check(f == 16, "R1", "cold access misses", 32'(f), 16);
    access(mk(2, 5, 3), 0, 0, 0, f);
    access(mk(3, 5, 3), 0, 0, 0, f);
    access(mk(4, 5, 3), 0, 0, 0, f);
    access(mk(4, 5, 7), 0, 0, 0, f); check(f == 0, "R7", "way filled while invalid", 32'(f), 0);
    access(mk(1, 5, 3), 0, 0, 0, f); check(f == 0, "R7", "first fill kept", 32'(f), 0);
    access(mk(5, 5, 3), 0, 0, 0, f); check(f == 16, "R8", "new tag misses", 32'(f), 16);
    access(mk(2, 5, 3), 0, 0, 0, f); check(f == 16, "R8", "lowest clear way evicted", 32'(f), 16);
    access(mk(1, 5, 3), 0, 0, 0, f); check(f == 0, "R8", "recent way kept", 32'(f), 0);
    access(mk(4, 5, 3), 0, 0, 0, f); check(f == 0, "R8", "most recent fill kept", 32'(f), 0);
    access(mk(3, 5, 3), 0, 0, 0, f); check(f == 16, "R8", "older way evicted", 32'(f), 16);
    access(mk(5, 5, 3), 0, 0, 0, f); check(f == 16, "R8", "bits cleared then evicted", 32'(f), 16);

    // R6 / R4 / R9: masked stores and dirty eviction in set 7
    access(mk(1, 7, 2), 1, 32'hAABB_CCDD, 4'b0101, f);
    check(f == 16, "R6", "write miss allocates", 32'(f), 16);
    access(mk(1, 7, 2), 0, 0, 0, f);
    access(mk(1, 7, 2), 1, 32'h1122_3344, 4'b1010, f);
    check(f == 0, "R4", "write hit no fill", 32'(f), 0);
    access(mk(1, 7, 2), 0, 0, 0, f);
    access(mk(2, 7, 0), 0, 0, 0, f);
    access(mk(3, 7, 0), 0, 0, 0, f);
    access(mk(4, 7, 0), 0, 0, 0, f);
    access(mk(5, 7, 0), 0, 0, 0, f);
    access(mk(1, 7, 2), 0, 0, 0, f);
    check(f == 16, "R9", "evicted line refetched", 32'(f), 16);

    // Random mix with a stalling memory, then with a zero-wait memory
    fast = 1'b0;
    for (int n = 0; n < 500; n++)
      access(mk($urandom % 6, $urandom % 3, $urandom % 16), $urandom % 2,
             $urandom, 4'($urandom), f);
    fast = 1'b1;
    for (int n = 0; n < 200; n++)
      access(mk($urandom % 6, 8 + $urandom % 2, $urandom % 16), $urandom % 2,
             $urandom, 4'($urandom), f);
    summary();
  end
endmodule